// File: doc/BRIEF.md
# Edge-Detecting General-Purpose I/O Controller

This block controls 28 general-purpose pins from a word-wide register bus. Software selects per pin whether it drives or listens. Output levels are changed through two write ports: one raises the chosen bits and the other lowers them, so no read-modify-write is needed. Input pins pass through a two-stage synchroniser. The synchronised samples are then compared cycle to cycle to find rising and falling transitions.

Each pin has its own rising and falling capture enables. A qualifying transition on an input pin sets a sticky status bit, and software clears that bit by writing a one to it. Pins 0 to 10 each drive their own interrupt line from their status bit. Pins 11 to 27 share one line that is the OR of their status bits. A 32-bit alternate-function word is stored and read back, and it does nothing else.

Register map: each register is one 32-bit word, selected by `bus_addr[4:2]`. Offsets are 0x00 level, 0x04 direction, 0x08 set, 0x0C clear, 0x10 rising enable, 0x14 falling enable, 0x18 status and 0x1C alternate function. Bits 1:0 of the address are ignored. Any address with a bit set above bit 4 lies outside the map.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are zero and all interrupt lines are low.
- R2: Direction register (offset 0x04): bit n at 1 makes pin n an output, shown on `pin_oe[n]`; a write replaces the whole register.
- R3: Writing the set register (offset 0x08) raises every output-latch bit written as 1 on the following cycle and leaves the other bits alone; reading offset 0x08 returns the last value written, bits 27:0.
- R4: Writing the clear register (offset 0x0C) lowers every output-latch bit written as 1; reading offset 0x0C always returns zero. The output latch always appears on `pin_out`.
- R5: Reading the level register (offset 0x00) returns, per pin, the output latch when the pin's direction bit is 1 and the synchronised input sample when it is 0.
- R6: A change on `pin_in` shows up in a level read after the second rising clock edge following the change.
- R7: With its rising enable set (offset 0x10), a 0-to-1 transition on an input pin sets that pin's status bit. The bit is set by the third rising clock edge after the pin changed.
- R8: With its falling enable set (offset 0x14), a 1-to-0 transition on an input pin sets that pin's status bit, with the same latency as R7.
- R9: A pin whose direction bit is 1 never sets its status bit, whatever its enables and its `pin_in` activity.
- R10: Writing 1s to the status register (offset 0x18) clears those bits and leaves the others. A transition detected in the same cycle as the clearing write wins, and its bit stays set.
- R11: `irq_pin[n]` equals status bit n for n from 0 to 10, and `irq_shared` is high whenever any status bit from 11 to 27 is set.
- R12: The alternate-function register (offset 0x1C) stores and returns all 32 bits and has no effect on pins, status or interrupts.
- R13: Bits 31:28 of every register other than alternate-function read zero. An address outside the map reads zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | 28 | Asynchronous pin inputs |
| pin_out | output | 28 | Output latch |
| pin_oe | output | 28 | Output enable, equal to the direction register |
| irq_pin | output | 11 | Dedicated interrupts for pins 0 to 10 |
| irq_shared | output | 1 | OR of status bits 11 to 27 |

## Verification
The bench puts a clearing write on the same cycle as a fresh transition on that pin. A design that gave the clear priority would lose the event, and the status bit would read zero where the reference still expects one. It toggles `pin_in` on pins set as outputs while both enables are on. A design that skipped the direction qualifier would raise status bits and interrupts there. It measures the level-read and status latency one cycle at a time, which exposes a synchroniser with one stage too few or too many. It also writes outside the map and reads the clear register, so a decoder that aliased addresses, or a clear register that returned data, would show non-zero read data or corrupted registers.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  // Register select taken from bus_addr[4:2]; software depends on this order.
  typedef enum logic [2:0] {
    RG_LEVEL = 3'd0,
    RG_DIR   = 3'd1,
    RG_SET   = 3'd2,
    RG_CLR   = 3'd3,
    RG_RISE  = 3'd4,
    RG_FALL  = 3'd5,
    RG_STAT  = 3'd6,
    RG_ALT   = 3'd7
  } reg_idx_e;

  localparam int unsigned IDX_LSB   = 2;
  localparam int unsigned IDX_WIDTH = 3;
  localparam int unsigned NUM_REGS  = 1 << IDX_WIDTH;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPIN = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] smp_cur,
  output logic [NPIN-1:0] smp_prev
);
  logic [NPIN-1:0] meta_q;

  // Two flops bring the input into the clock domain; a third keeps the old sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      smp_cur  <= '0;
      smp_prev <= '0;
    end else begin
      meta_q   <= pin_in;
      smp_cur  <= meta_q;
      smp_prev <= smp_cur;
    end
  end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int unsigned NPIN = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] smp_cur,
  input  logic [NPIN-1:0] smp_prev,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  input  logic [NPIN-1:0] dir,
  input  logic [NPIN-1:0] clr_vec,
  output logic [NPIN-1:0] hit_vec,
  output logic [NPIN-1:0] status
);
  // Qualified transitions: enabled direction of change, input pins only.
  function automatic logic [NPIN-1:0] edge_hits(
    input logic [NPIN-1:0] cur, input logic [NPIN-1:0] prev,
    input logic [NPIN-1:0] ren, input logic [NPIN-1:0] fen,
    input logic [NPIN-1:0] outs);
    logic [NPIN-1:0] up, down;
    up   = cur & ~prev;
    down = ~cur & prev;
    return ((up & ren) | (down & fen)) & ~outs;
  endfunction

  assign hit_vec = edge_hits(smp_cur, smp_prev, rise_en, fall_en, dir);

  // Setting has priority over the write-one-to-clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | hit_vec;
  end

  a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_vec & ~hit_vec)) == '0));

  a_r7_hit_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |-> (smp_cur != smp_prev));
endmodule

// File: rtl/gpio_irq_fan.sv
module gpio_irq_fan #(
  parameter int unsigned NPIN = 28,
  parameter int unsigned NDED = 11
) (
  input  logic [NPIN-1:0] status,
  output logic [NDED-1:0] irq_pin,
  output logic            irq_shared
);
  for (genvar i = 0; i < NDED; i++) begin : g_dedicated
    assign irq_pin[i] = status[i];
  end
  assign irq_shared = |status[NPIN-1:NDED];
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPIN   = 28,
  parameter int unsigned NDED   = 11,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NDED-1:0]   irq_pin,
  output logic              irq_shared
);
  localparam int unsigned MAP_TOP = IDX_LSB + IDX_WIDTH;
  localparam int unsigned PAD_W   = DW - NPIN;

  logic              in_map;
  reg_idx_e          idx;
  logic              wr_en;
  logic [NUM_REGS-1:0] wr_hit;
  logic [NPIN-1:0]   wmask;
  logic              unused_addr_lsb;

  logic [NPIN-1:0] dir_q, out_q, set_shadow_q, rise_q, fall_q;
  logic [DW-1:0]   alt_q;
  logic [NPIN-1:0] smp_cur, smp_prev, hit_vec, stat_q, clr_vec;

  assign in_map          = (bus_addr[ADDR_W-1:MAP_TOP] == '0);
  assign idx             = reg_idx_e'(bus_addr[IDX_LSB +: IDX_WIDTH]);
  assign wr_en           = bus_sel & bus_wr & in_map;
  assign wmask           = bus_wdata[NPIN-1:0];
  assign unused_addr_lsb = ^bus_addr[IDX_LSB-1:0];

  always_comb begin
    wr_hit = '0;
    if (wr_en) wr_hit[idx] = 1'b1;
  end

  assign clr_vec = wr_hit[RG_STAT] ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q        <= '0;
      out_q        <= '0;
      set_shadow_q <= '0;
      rise_q       <= '0;
      fall_q       <= '0;
      alt_q        <= '0;
    end else begin
      if (wr_hit[RG_DIR])  dir_q  <= wmask;
      if (wr_hit[RG_RISE]) rise_q <= wmask;
      if (wr_hit[RG_FALL]) fall_q <= wmask;
      if (wr_hit[RG_ALT])  alt_q  <= bus_wdata;
      if (wr_hit[RG_SET]) begin
        out_q        <= out_q | wmask;
        set_shadow_q <= wmask;
      end
      if (wr_hit[RG_CLR])  out_q  <= out_q & ~wmask;
    end
  end

  gpio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .smp_cur  (smp_cur),
    .smp_prev (smp_prev)
  );

  gpio_edge_status #(.NPIN(NPIN)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_cur  (smp_cur),
    .smp_prev (smp_prev),
    .rise_en  (rise_q),
    .fall_en  (fall_q),
    .dir      (dir_q),
    .clr_vec  (clr_vec),
    .hit_vec  (hit_vec),
    .status   (stat_q)
  );

  gpio_irq_fan #(.NPIN(NPIN), .NDED(NDED)) u_irq (
    .status     (stat_q),
    .irq_pin    (irq_pin),
    .irq_shared (irq_shared)
  );

  function automatic logic [NPIN-1:0] pin_level(
    input logic [NPIN-1:0] latch, input logic [NPIN-1:0] outs,
    input logic [NPIN-1:0] smp);
    return (latch & outs) | (smp & ~outs);
  endfunction

  function automatic logic [DW-1:0] widen(input logic [NPIN-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      unique case (idx)
        RG_LEVEL: bus_rdata = widen(pin_level(out_q, dir_q, smp_cur));
        RG_DIR:   bus_rdata = widen(dir_q);
        RG_SET:   bus_rdata = widen(set_shadow_q);
        RG_CLR:   bus_rdata = '0;
        RG_RISE:  bus_rdata = widen(rise_q);
        RG_FALL:  bus_rdata = widen(fall_q);
        RG_STAT:  bus_rdata = widen(stat_q);
        RG_ALT:   bus_rdata = alt_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[RG_SET] |=> ((out_q & $past(wmask)) == $past(wmask)));

  a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[RG_CLR] |=> ((out_q & $past(wmask)) == '0));

  a_r9_no_output_latch: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(dir_q)) == '0));

  a_r11_shared_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_shared) |-> ($past(hit_vec[NPIN-1:NDED]) != '0));
endmodule

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [27:0] pin_in = '0;
  logic [27:0] pin_out, pin_oe;
  logic [10:0] irq_pin;
  logic        irq_shared;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit go = 0, done = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  gpio_edge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_pin(irq_pin), .irq_shared(irq_shared)
  );

  // Behavioural reference state
  logic [27:0] m_dir, m_out, m_setsh, m_rise, m_fall, m_stat, m_s1, m_s2, m_prev;
  logic [31:0] m_alt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 0; m_out = 0; m_setsh = 0; m_rise = 0; m_fall = 0;
      m_stat = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_alt = 0;
    end else begin
      logic [27:0] ev, nstat, wd;
      bit w;
      int ix;
      ev = 0;
      for (int i = 0; i < 28; i++) begin
        if (!m_dir[i]) begin
          if (m_s2[i] && !m_prev[i] && m_rise[i]) ev[i] = 1'b1;
          if (!m_s2[i] && m_prev[i] && m_fall[i]) ev[i] = 1'b1;
        end
      end
      wd = bus_wdata[27:0];
      w  = bus_sel && bus_wr && (int'(bus_addr) < 32);
      ix = int'(bus_addr) / 4;
      nstat = m_stat;
      if (w && ix == 6) nstat = nstat & ~wd;
      nstat = nstat | ev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (w) begin
        case (ix)
          1: m_dir = wd;
          2: begin m_out = m_out | wd; m_setsh = wd; end
          3: m_out = m_out & ~wd;
          4: m_rise = wd;
          5: m_fall = wd;
          7: m_alt = bus_wdata;
          default: ;
        endcase
      end
      m_stat = nstat;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    logic [27:0] lv;
    if (int'(a) >= 32) return 32'h0;
    case (int'(a) / 4)
      0: begin
        for (int i = 0; i < 28; i++) lv[i] = m_dir[i] ? m_out[i] : m_s2[i];
        return {4'h0, lv};
      end
      1: return {4'h0, m_dir};
      2: return {4'h0, m_setsh};
      3: return 32'h0;
      4: return {4'h0, m_rise};
      5: return {4'h0, m_fall};
      6: return {4'h0, m_stat};
      default: return m_alt;
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", cur_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && go && !done) begin
      chk("bus_rdata", bus_rdata, exp_rd(bus_addr));
      chk("pin_oe", {4'h0, pin_oe}, {4'h0, m_dir});
      chk("pin_out", {4'h0, pin_out}, {4'h0, m_out});
      chk("irq_pin", {21'h0, irq_pin}, {21'h0, m_stat[10:0]});
      chk("irq_shared", {31'h0, irq_shared}, {31'h0, |m_stat[27:11]});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog %s actual=running expected=finished", cur_tag);
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic sweep();
    for (int a = 0; a < 10; a++) begin
      bus_addr = 6'(a * 4);
      step(1);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1;
    go = 1;
    step(1);
    cur_tag = "R1";  sweep();
    cur_tag = "R2";  wreg(6'h04, 32'h0F00_00FF); sweep();
    cur_tag = "R3";  wreg(6'h08, 32'hFFFF_0F35); sweep();
    cur_tag = "R4";  wreg(6'h0C, 32'h0000_0F11); sweep();
    cur_tag = "R5";  pin_in = 28'hAAA_5555; sweep(); pin_in = 28'h555_AAAA; sweep();
    cur_tag = "R6";  bus_addr = 6'h00;
    for (int k = 0; k < 6; k++) begin pin_in = ~pin_in; step(3); end
    cur_tag = "R7";  wreg(6'h10, 32'hFFFF_FFFF); pin_in = 0; step(4);
    pin_in = 28'hF0F_0F0F; bus_addr = 6'h18; step(5); sweep();
    cur_tag = "R8";  wreg(6'h18, 32'hFFFF_FFFF); wreg(6'h10, 0); wreg(6'h14, 32'h0FFF_FFFF);
    pin_in = 0; bus_addr = 6'h18; step(5); sweep();
    cur_tag = "R9";  wreg(6'h18, 32'hFFFF_FFFF); wreg(6'h10, 32'h0FFF_FFFF);
    for (int k = 0; k < 4; k++) begin pin_in[7:0] = ~pin_in[7:0]; step(4); end
    sweep();
    cur_tag = "R10"; wreg(6'h18, 32'h0000_0100); bus_addr = 6'h18;
    pin_in[20] = 1'b1; step(2); wreg(6'h18, 32'h0010_0000); step(3);
    wreg(6'h18, 32'h0010_0000); step(3);
    cur_tag = "R11"; wreg(6'h18, 32'hFFFF_FFFF); wreg(6'h04, 0); pin_in = 0; step(4);
    wreg(6'h18, 32'hFFFF_FFFF); pin_in[5] = 1; step(5); pin_in[25] = 1; step(5);
    wreg(6'h18, 32'h0000_0020); step(3); wreg(6'h18, 32'h0200_0000); step(3);
    cur_tag = "R12"; wreg(6'h1C, 32'hDEAD_BEEF); pin_in = 28'h123_4567; step(5); sweep();
    cur_tag = "R13"; wreg(6'h24, 32'hFFFF_FFFF); wreg(6'h3C, 32'hFFFF_FFFF);
    bus_addr = 6'h2C; step(2); sweep();
    cur_tag = "R7";
    for (int k = 0; k < 3000; k++) begin
      pin_in = 28'($urandom);
      bus_addr = 6'($urandom);
      if (($urandom % 4) == 0) begin
        bus_sel = 1; bus_wr = 1; bus_wdata = $urandom;
      end
      step(1);
      bus_sel = 0; bus_wr = 0;
    end
    step(2);
    finish_run();
  end
endmodule